// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds a processor's global control registers and serves move-to and move-from requests on them. Each request gives a 7-bit register index, a direction bit, 64-bit write data and the requester's current privilege level. One clock edge later the block answers with a registered response: a valid flag, a two-bit fault code and 64 bits of data. Reads return the register contents. Writes return the value as it was stored, which is the forwarded new value.

Five registers are writable: default control, interval timer match, interruption vector address, interval timer offset and page table address. Five more are read-only views of interrupt state taken from a status input. These are the highest-pending-vector register and four 64-bit pending-request words. Every access is screened before anything changes. A requester that is not at privilege 0 is refused first. Then an index with no register behind it is refused. Then a write to a read-only register is refused. A refused access leaves every register as it was.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, rsp_valid is 0 and every writable register reads as zero.
- R2: A request with req_pl other than 0 answers fault code 1 (privileged) for every index and direction, and it changes no register.
- R3: With req_pl = 0, a read or a write to an index other than 0, 1, 2, 4, 8, 65 and 68 to 71 answers fault code 2 (illegal) and changes no register.
- R4: With req_pl = 0, a write to index 65 or to indices 68 to 71 answers fault code 2 (illegal) and changes no register.
- R5: The writable registers sit at index 0 (default control), 1 (timer match), 2 (vector address), 4 (timer offset) and 8 (page table address). A read returns the value of the latest earlier accepted write to the same index.
- R6: Bits 14:0 of the vector address register (index 2) always read as zero, whatever was written.
- R7: A read of index 68+k (k = 0..3) returns bits 64k+63 down to 64k of irq_status, as sampled at the request edge.
- R8: A read of index 65 returns, zero-extended, the highest bit number set in irq_status. It returns 15 when no bit is set.
- R9: An accepted write answers fault code 0 and returns the value as it is now stored.
- R10: Fault code 0 means success. Any response with a non-zero fault code carries all-zero data.
- R11: A response appears on the clock edge that samples the request. rsp_valid equals req_valid delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_idx | input | 7 | Register index |
| req_wr | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_wdata | input | 64 | Write data |
| req_pl | input | 2 | Current privilege level of the requester |
| irq_status | input | 256 | Pending interrupt bits, bit n = interrupt n |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 2 | 0 none, 1 privileged, 2 illegal |
| rsp_rdata | output | 64 | Read data or stored write value, zero on fault |

## Verification
The fault screen and the register update both act in the same cycle as any write. Every write request therefore tests whether a refused access leaks into storage. The bench sweeps all 128 indices with writes at privilege 0 and then at privilege 1 to 3. After each sweep it reads back every writable register and compares it with a model that only accepted writes change. It also compares each write's echoed data with the value that the next read returns, including the forced-zero low bits of the vector address register.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_PRIV = 2'd1,
      FLT_ILL  = 2'd2
   } flt_e;

   localparam int NUM_GLOB = 5;
   localparam int SLOT_W   = 3;
   localparam int IVA_SLOT = 2;
   localparam int VEC_IDX  = 65;
   localparam int IRR_BASE = 68;

   // index of writable slot s: 0,1,2,4,8
   function automatic int glob_index(int s);
      if (s < 3) return s;
      else if (s == 3) return 4;
      else return 8;
   endfunction
endpackage

// File: rtl/ctl_idx_decode.sv
module ctl_idx_decode
   import ctl_regbank_pkg::*;
#(
   parameter int IDX_W   = 7,
   parameter int NUM_IRR = 4,
   localparam int IRR_SW = (NUM_IRR > 1) ? $clog2(NUM_IRR) : 1
) (
   input  logic [IDX_W-1:0]  idx,
   output logic              is_glob,
   output logic [SLOT_W-1:0] slot,
   output logic              is_vec,
   output logic              is_irr,
   output logic [IRR_SW-1:0] irr_sel
);
   logic [NUM_GLOB-1:0] hit;
   logic [IDX_W-1:0]    irr_off;

   for (genvar g = 0; g < NUM_GLOB; g++) begin : g_hit
      assign hit[g] = (idx == IDX_W'(glob_index(g)));
   end

   always_comb begin
      slot = '0;
      for (int g = 0; g < NUM_GLOB; g++)
         if (hit[g]) slot = SLOT_W'(g);
   end

   assign is_glob = |hit;
   assign is_vec  = (idx == IDX_W'(VEC_IDX));
   assign irr_off = idx - IDX_W'(IRR_BASE);
   assign is_irr  = (idx >= IDX_W'(IRR_BASE)) && (irr_off < IDX_W'(NUM_IRR));
   assign irr_sel = irr_off[IRR_SW-1:0];
endmodule

// File: rtl/ctl_glob_regs.sv
module ctl_glob_regs
   import ctl_regbank_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int IVA_ALIGN = 15
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SLOT_W-1:0]              wr_slot,
   input  logic [XLEN-1:0]                wdata,
   output logic [XLEN-1:0]                wr_value,
   output logic [NUM_GLOB-1:0][XLEN-1:0]  q
);
   localparam logic [XLEN-1:0] IVA_KEEP = {XLEN{1'b1}} << IVA_ALIGN;

   assign wr_value = (wr_slot == SLOT_W'(IVA_SLOT)) ? (wdata & IVA_KEEP) : wdata;

   for (genvar g = 0; g < NUM_GLOB; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[g] <= '0;
         else if (wr_en && wr_slot == SLOT_W'(g))
            q[g] <= wr_value;
      end
   end
endmodule

// File: rtl/ctl_irq_pick.sv
module ctl_irq_pick #(
   parameter int N        = 256,
   parameter int VW       = 8,
   parameter int NONE_VEC = 15
) (
   input  logic [N-1:0]  pend,
   output logic [VW-1:0] vec
);
   always_comb begin
      vec = VW'(NONE_VEC);
      for (int i = 0; i < N; i++)
         if (pend[i]) vec = VW'(i);
   end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
   import ctl_regbank_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int IDX_W     = 7,
   parameter int NUM_IRR   = 4,
   parameter int IVA_ALIGN = 15,
   parameter int NONE_VEC  = 15,
   localparam int IRQ_N    = NUM_IRR * XLEN,
   localparam int VEC_W    = $clog2(IRQ_N),
   localparam int IRR_SW   = (NUM_IRR > 1) ? $clog2(NUM_IRR) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic              req_wr,
   input  logic [XLEN-1:0]   req_wdata,
   input  logic [1:0]        req_pl,
   input  logic [IRQ_N-1:0]  irq_status,
   output logic              rsp_valid,
   output logic [1:0]        rsp_fault,
   output logic [XLEN-1:0]   rsp_rdata
);
   if (IDX_W < 7) begin : g_bad_idx
      $error("IDX_W must reach index 71");
   end
   if (NUM_IRR < 1 || NUM_IRR > 4) begin : g_bad_irr
      $error("NUM_IRR must be 1 to 4");
   end
   if (IVA_ALIGN < 0 || IVA_ALIGN >= XLEN) begin : g_bad_align
      $error("IVA_ALIGN out of range");
   end
   if (NONE_VEC >= IRQ_N || VEC_W > XLEN) begin : g_bad_vec
      $error("NONE_VEC or vector width out of range");
   end

   logic                          is_glob, is_vec, is_irr;
   logic [SLOT_W-1:0]             slot;
   logic [IRR_SW-1:0]             irr_sel;
   logic [NUM_GLOB-1:0][XLEN-1:0] greg;
   logic [XLEN-1:0]               wr_value;
   logic [VEC_W-1:0]              top_vec;
   flt_e                          flt;
   logic                          wr_en;
   logic [XLEN-1:0]               rdata_d;

   ctl_idx_decode #(.IDX_W(IDX_W), .NUM_IRR(NUM_IRR)) u_dec (
      .idx(req_idx), .is_glob(is_glob), .slot(slot),
      .is_vec(is_vec), .is_irr(is_irr), .irr_sel(irr_sel)
   );

   ctl_glob_regs #(.XLEN(XLEN), .IVA_ALIGN(IVA_ALIGN)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(slot),
      .wdata(req_wdata), .wr_value(wr_value), .q(greg)
   );

   ctl_irq_pick #(.N(IRQ_N), .VW(VEC_W), .NONE_VEC(NONE_VEC)) u_pick (
      .pend(irq_status), .vec(top_vec)
   );

   // screen order: privilege, then unmapped index, then read-only target
   always_comb begin
      if (req_pl != 2'd0)
         flt = FLT_PRIV;
      else if (!(is_glob || is_vec || is_irr))
         flt = FLT_ILL;
      else if (req_wr && !is_glob)
         flt = FLT_ILL;
      else
         flt = FLT_NONE;
   end

   assign wr_en = req_valid && req_wr && is_glob && (flt == FLT_NONE);

   always_comb begin
      rdata_d = '0;
      if (flt == FLT_NONE) begin
         if (req_wr)
            rdata_d = wr_value;
         else if (is_glob)
            rdata_d = greg[slot];
         else if (is_vec)
            rdata_d = XLEN'(top_vec);
         else
            rdata_d = irq_status[irr_sel*XLEN +: XLEN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= FLT_NONE;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_fault <= req_valid ? flt : FLT_NONE;
         rsp_rdata <= req_valid ? rdata_d : '0;
      end
   end
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
   import ctl_regbank_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int IDX_W     = 7,
   parameter int NUM_IRR   = 4,
   parameter int IVA_ALIGN = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [IDX_W-1:0] req_idx,
   input logic             req_wr,
   input logic [1:0]       req_pl,
   input logic             rsp_valid,
   input logic [1:0]       rsp_fault,
   input logic [XLEN-1:0]  rsp_rdata
);
   logic ro_idx, mapped;
   assign ro_idx = (int'(req_idx) == VEC_IDX) ||
                   (int'(req_idx) >= IRR_BASE && int'(req_idx) < IRR_BASE + NUM_IRR);
   assign mapped = ro_idx || req_idx == 0 || req_idx == 1 || req_idx == 2 ||
                   req_idx == 4 || req_idx == 8;

   assert_priv_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_pl != 2'd0 |=> rsp_fault == 2'd1);

   assert_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_pl == 2'd0 && !mapped |=> rsp_fault == 2'd2);

   assert_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_pl == 2'd0 && req_wr && ro_idx |=> rsp_fault == 2'd2);

   assert_iva_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_idx == 2 |=> rsp_rdata[IVA_ALIGN-1:0] == '0);

   assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 2'd0 |-> rsp_rdata == '0);

   assert_rsp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));
endmodule

bind ctl_regbank ctl_regbank_chk #(
   .XLEN(XLEN), .IDX_W(IDX_W), .NUM_IRR(NUM_IRR), .IVA_ALIGN(IVA_ALIGN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
   .req_wr(req_wr), .req_pl(req_pl), .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
);

// File: tb/ctl_regbank_test.sv
module ctl_regbank_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [6:0]   req_idx = '0;
   logic         req_wr = 1'b0;
   logic [63:0]  req_wdata = '0;
   logic [1:0]   req_pl = '0;
   logic [255:0] irq_status = '0;
   logic         rsp_valid;
   logic [1:0]   rsp_fault;
   logic [63:0]  rsp_rdata;

   int checks = 0;
   int errors = 0;
   logic [63:0] mdl [5];

   always #10 clk = ~clk;

   ctl_regbank uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
      .req_wr(req_wr), .req_wdata(req_wdata), .req_pl(req_pl),
      .irq_status(irq_status), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", r, act, exp);
      end
   endtask

   function automatic int slot_of(input int idx);
      case (idx)
         0: return 0;  1: return 1;  2: return 2;
         4: return 3;  8: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic logic [63:0] top_pending(input logic [255:0] s);
      for (int i = 255; i >= 0; i--)
         if (s[i]) return 64'(i);
      return 64'd15;
   endfunction

   // one request: drive at negedge, check at the next negedge
   task automatic access(input int idx, input bit wr, input logic [63:0] wd, input int pl);
      int s;
      bit ro;
      logic [1:0] ef;
      logic [63:0] ed;
      string tag;
      s  = slot_of(idx);
      ro = (idx == 65) || (idx >= 68 && idx <= 71);
      ed = '0;
      if (pl != 0) begin ef = 2'd1; tag = "R2"; end
      else if (s < 0 && !ro) begin ef = 2'd2; tag = "R3"; end
      else if (wr && ro) begin ef = 2'd2; tag = "R4"; end
      else begin
         ef = 2'd0;
         if (wr) begin
            ed = (s == 2) ? (wd & ~64'h7FFF) : wd;
            tag = "R9";
         end else if (s >= 0) begin
            ed = mdl[s];
            tag = "R5";
         end else if (idx == 65) begin
            ed = top_pending(irq_status);
            tag = "R8";
         end else begin
            ed = irq_status[(idx-68)*64 +: 64];
            tag = "R7";
         end
      end
      req_valid = 1'b1;
      req_idx   = 7'(idx);
      req_wr    = wr;
      req_wdata = wd;
      req_pl    = 2'(pl);
      @(negedge clk);
      chk("R11 valid", 64'(rsp_valid), 64'd1);
      chk({tag, " fault"}, 64'(rsp_fault), 64'(ef));
      chk((ef != 0) ? "R10 data" : {tag, " data"}, rsp_rdata, ed);
      if (idx == 2 && ef == 0)
         chk("R6 align", 64'(rsp_rdata[14:0]), 64'd0);
      if (ef == 0 && wr && s >= 0)
         mdl[s] = ed;
   endtask

   task automatic read_back_all(input string r);
      int gi [5] = '{0, 1, 2, 4, 8};
      foreach (gi[k]) begin
         access(gi[k], 1'b0, '0, 0);
         chk(r, rsp_rdata, mdl[k]);
      end
   endtask

   initial begin
      #3_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      foreach (mdl[k]) mdl[k] = '0;
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle", 64'(rsp_valid), 64'd0);
      read_back_all("R1 reset value");

      irq_status = {64'hF00D_0000_0000_0001, 64'h8000_0000_0000_0000,
                    64'h0000_0001_2345_0000, 64'h0000_0000_0000_0080};

      // pass 1: writes then reads over all indices, privilege 0
      for (int i = 0; i < 128; i++)
         access(i, 1'b1, 64'hA5C3_5A3C_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0101), 0);
      read_back_all("R3 R4 no change");
      for (int i = 0; i < 128; i++)
         access(i, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 0);

      // pass 2: every index at each non-zero privilege level
      for (int pl = 1; pl < 4; pl++)
         for (int i = 0; i < 128; i++) begin
            access(i, 1'b1, ~64'(i * pl), pl);
            access(i, 1'b0, '0, pl);
         end
      read_back_all("R2 no change");

      // vector address: all-ones write keeps its low bits clear
      access(2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      access(2, 1'b0, '0, 0);

      // highest-pending vector patterns
      irq_status = '0;
      access(65, 1'b0, '0, 0);
      for (int b = 0; b < 256; b += 17) begin
         irq_status = '0;
         irq_status[b] = 1'b1;
         access(65, 1'b0, '0, 0);
         irq_status[b/2] = 1'b1;
         access(65, 1'b0, '0, 0);
      end
      irq_status = '0;
      irq_status[255] = 1'b1;
      irq_status[3] = 1'b1;
      access(65, 1'b0, '0, 0);
      for (int k = 68; k < 72; k++)
         access(k, 1'b0, '0, 0);

      req_valid = 1'b0;
      @(negedge clk);
      chk("R11 idle", 64'(rsp_valid), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule